// File: doc/BRIEF.md
# Memory-Mapped Serial Port Register Block

This block is the software-facing register file of a simple serial port. A bus master reaches four word-spaced registers in a 16-byte window: a receive data port, a transmit data port, a read-only status word and a control word. Bytes coming from an external deserializer arrive on a byte stream with a valid strobe. They are held in an eight-entry receive queue until software reads them, one byte per read of the receive port. Each write to the transmit port sends its low byte straight out on a transmit byte stream, with a one-cycle strobe.

One level-sensitive interrupt line is driven from a sticky pending flag and an enable bit held in the control word. The pending flag is set by received data and by every transmit write. Software clears it by reading the status word once the receive queue is empty. The control word also carries self-clearing commands that flush the queues. No transmit buffering exists, so the transmit status bits are constant. The error status bits read as zero.

Bus reads are combinational: `bus_rdata` reflects the addressed register in the same cycle. Side effects, such as removing a byte or clearing the pending flag, take place at the clock edge that ends the read. The master is expected to assert at most one of `bus_rd` and `bus_wr` in a cycle.

Top module: `serport_regs`

## Requirements
- R1: After reset the status word reads 0x04, the control word reads 0, a receive-port read returns 0, `irq` is 0 and `tx_out_valid` is 0.
- R2: The register index is byte address bits [3:2]: 0 is receive data, 1 is transmit data, 2 is status, 3 is control. Address bits [1:0] are ignored.
- R3: The receive queue holds up to 8 bytes. Each read of the receive port returns the oldest stored byte in bits [7:0], with the upper bits zero, and removes that byte.
- R4: Status bit 0 is 1 exactly when the queue holds at least one byte. Status bit 1 is 1 exactly when it holds 8.
- R5: A byte strobed in while the queue holds 8 bytes is discarded, and the stored bytes and their order are unchanged. This also holds when a receive-port read happens in the same cycle.
- R6: A receive-port read while the queue is empty returns the byte stored in the slot the read pointer addresses. It leaves the queue empty.
- R7: A control write with bit 1 set empties the queue by returning both pointers to slot 0, without erasing slot contents. A byte strobed in during that cycle is discarded. Bits 0 and 1 always read back as 0, and bit 0 has no observable effect.
- R8: A write to the transmit port drives its bits [7:0] on `tx_out_data` with `tx_out_valid` high for exactly the one cycle after the write.
- R9: Status bit 4, the pending flag, becomes 1 after any transmit write and whenever the queue is non-empty. It stays 1 until it is cleared as described in R10.
- R10: A status read returns the pending flag as it was before the read. It then clears the flag, unless the queue is non-empty after that cycle.
- R11: Control bit 4 is the interrupt enable and reads back as written. `irq` is 1 exactly when the pending flag and the enable are both 1.
- R12: Writes to the status word change nothing. Status bit 2 always reads 1, and bits 3, 5, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 4 | Byte address within the register window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| rx_in_data | input | 8 | Received byte from the deserializer |
| rx_in_valid | input | 1 | Receive byte strobe |
| tx_out_data | output | 8 | Byte for the serializer |
| tx_out_valid | output | 1 | One-cycle transmit strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The queue is swept over every fill level from empty to one byte past full. At each level the bench checks the status bits and then drains the queue, checking the byte order. Byte values differ per level, so a stale, reordered or overwritten slot shows up as a wrong value rather than as a count error. The pending flag and the enable are driven through all four combinations, to show that the interrupt is masked and that status reads clear only when the queue is empty. Further cases cover the collisions: an arrival while full together with a read, and an arrival during a flush. Addresses with nonzero low bits tell decode faults apart from register faults.

// File: rtl/serport_pkg.sv
// Shared register indices and bit positions for the serial port register block.
// Assumes the four registers sit at word indices 0..3 of the window.
package serport_pkg;
    typedef enum logic [1:0] {
        IDX_RXDATA = 2'd0,
        IDX_TXDATA = 2'd1,
        IDX_STATUS = 2'd2,
        IDX_CTRL   = 2'd3
    } reg_idx_e;

    localparam int ST_RXVLD   = 0;
    localparam int ST_RXFULL  = 1;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TXFULL  = 3;
    localparam int ST_PEND    = 4;

    localparam int CT_TXFLUSH = 0;
    localparam int CT_RXFLUSH = 1;
    localparam int CT_IEN     = 4;
endpackage

// File: rtl/serport_rxq.sv
// Receive byte queue: circular store with a write pointer, a read pointer and an occupancy count.
// Assumes that a flush overrides both push and pop in the same cycle, and that a push
// while full is dropped, even when a pop happens in the same cycle.
// Slot contents survive a flush. An empty pop leaves the queue unchanged.
module serport_rxq #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic              flush,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              nonempty,
    output logic              nonempty_next
);
    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              take;
    logic              give;
    logic [CNT_W-1:0]  count_next;

    // Qualify the requests against occupancy and flush.
    always_comb begin
        full       = (count == CNT_W'(DEPTH));
        nonempty   = (count != '0);
        take       = push && !full && !flush;
        give       = pop && nonempty && !flush;
        count_next = flush ? '0 : CNT_W'(count + CNT_W'(take) - CNT_W'(give));
        nonempty_next = (count_next != '0);
        head_data  = slots[rd_ptr];
    end

    // Advance the pointers and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= count_next;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (take) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                if (give) rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    // Store accepted bytes. Reset clears every slot so that empty reads are defined.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[s] <= '0;
            else if (take && wr_ptr == PTR_W'(s))
                slots[s] <= push_data;
        end
    end
endmodule

// File: rtl/serport_irqctl.sv
// Interrupt control: the sticky pending flag, the interrupt enable bit and the masked request line.
// Assumes that the caller raises set_tx for transmit writes and clr_rd for status reads,
// and supplies the queue's non-empty state after the current cycle.
module serport_irqctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tx,
    input  logic clr_rd,
    input  logic q_nonempty_next,
    input  logic ien_wr,
    input  logic ien_val,
    output logic pend,
    output logic ien,
    output logic irq
);
    // Pending flag: set by sources, cleared only by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !clr_rd) || set_tx || q_nonempty_next;
    end

    // Interrupt enable, loaded on control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien <= 1'b0;
        else if (ien_wr) ien <= ien_val;
    end

    // Masked request.
    always_comb irq = pend && ien;
endmodule

// File: rtl/serport_txstage.sv
// Transmit stage: registers the written byte and raises a strobe for one cycle.
// Assumes the downstream serializer accepts a byte on every strobe, so no buffering exists.
module serport_txstage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [DATA_W-1:0] send_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid
);
    // Capture the byte and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= send;
            if (send) out_data <= send_data;
        end
    end
endmodule

// File: rtl/serport_regs.sv
// Serial port register block top: address decode, status assembly, read mux and submodule wiring.
// Assumes at most one of bus_rd and bus_wr per cycle. Reads are combinational and their side
// effects take place at the closing clock edge.
module serport_regs #(
    parameter int RXQ_DEPTH = 8,
    parameter int BUS_W     = 32,
    parameter int BYTE_W    = 8,
    localparam int ADDR_W   = 4,
    localparam int CNT_W    = $clog2(RXQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BYTE_W-1:0] rx_in_data,
    input  logic              rx_in_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    output logic              tx_out_valid,
    output logic              irq
);
    import serport_pkg::*;

    reg_idx_e          idx;
    logic              rd_rx, wr_tx, rd_st, wr_ct;
    logic [BYTE_W-1:0] rxq_head;
    logic [CNT_W-1:0]  rxq_count;
    logic              rxq_full, rxq_nonempty, rxq_nonempty_next;
    logic              pend_q, ien_q;
    logic [BUS_W-1:0]  status_word;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:CT_IEN+1],
                            bus_wdata[CT_IEN-1:CT_RXFLUSH+1], bus_wdata[CT_TXFLUSH]};

    // Decode the word index into access strobes.
    always_comb begin
        idx   = reg_idx_e'(bus_addr[3:2]);
        rd_rx = bus_rd && (idx == IDX_RXDATA);
        rd_st = bus_rd && (idx == IDX_STATUS);
        wr_tx = bus_wr && (idx == IDX_TXDATA);
        wr_ct = bus_wr && (idx == IDX_CTRL);
    end

    serport_rxq #(.DEPTH(RXQ_DEPTH), .DATA_W(BYTE_W)) u_rxq (
        .clk           (clk),
        .rst_n         (rst_n),
        .push          (rx_in_valid),
        .push_data     (rx_in_data),
        .pop           (rd_rx),
        .flush         (wr_ct && bus_wdata[CT_RXFLUSH]),
        .head_data     (rxq_head),
        .count         (rxq_count),
        .full          (rxq_full),
        .nonempty      (rxq_nonempty),
        .nonempty_next (rxq_nonempty_next)
    );

    serport_irqctl u_irq (
        .clk             (clk),
        .rst_n           (rst_n),
        .set_tx          (wr_tx),
        .clr_rd          (rd_st),
        .q_nonempty_next (rxq_nonempty_next),
        .ien_wr          (wr_ct),
        .ien_val         (bus_wdata[CT_IEN]),
        .pend            (pend_q),
        .ien             (ien_q),
        .irq             (irq)
    );

    serport_txstage #(.DATA_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (wr_tx),
        .send_data (bus_wdata[BYTE_W-1:0]),
        .out_data  (tx_out_data),
        .out_valid (tx_out_valid)
    );

    // Assemble the status word. Transmit is unbuffered, and error bits are fixed at zero.
    always_comb begin
        status_word             = '0;
        status_word[ST_RXVLD]   = rxq_nonempty;
        status_word[ST_RXFULL]  = rxq_full;
        status_word[ST_TXEMPTY] = 1'b1;
        status_word[ST_TXFULL]  = 1'b0;
        status_word[ST_PEND]    = pend_q;
    end

    // Select the read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_RXDATA: bus_rdata[BYTE_W-1:0] = rxq_head;
            IDX_STATUS: bus_rdata = status_word;
            IDX_CTRL:   bus_rdata[CT_IEN] = ien_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/serport_regs_chk.sv
// Property checker for the serial port register block, attached by bind.
// Assumes it sees the top's ports plus its queue count and pending flag.
module serport_regs_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             rx_in_valid,
    input logic [7:0]       tx_out_data,
    input logic             tx_out_valid,
    input logic             irq,
    input logic [CNT_W-1:0] q_count,
    input logic             pend
);
    // R8
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == 2'd1) |=> (tx_out_valid && tx_out_data == $past(bus_wdata[7:0])));
    // R8
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[3:2] == 2'd1) |=> !tx_out_valid);
    // R7
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == 2'd3 && bus_wdata[1]) |=> (q_count == '0));
    // R5
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CNT_W'(DEPTH) && rx_in_valid && !bus_rd && !bus_wr) |=> (q_count == CNT_W'(DEPTH)));
    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));
    // R9
    pend_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count != '0) |-> pend);
    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == 2'd3 && !bus_wdata[4]) |=> !irq);
    // R12
    status_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[3:2] == 2'd2) |-> (bus_rdata[2] && !bus_rdata[3] && bus_rdata[7:5] == 3'd0));
endmodule

bind serport_regs serport_regs_chk #(.DEPTH(RXQ_DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .rx_in_valid  (rx_in_valid),
    .tx_out_data  (tx_out_data),
    .tx_out_valid (tx_out_valid),
    .irq          (irq),
    .q_count      (rxq_count),
    .pend         (pend_q)
);

// File: tb/serport_regs_test.sv
module serport_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_in_data = '0;
    logic        rx_in_valid = 1'b0;
    logic [7:0]  tx_out_data;
    logic        tx_out_valid;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // Reference state kept from the requirements.
    logic [7:0] m_slot [8];
    int m_wp = 0, m_rp = 0, m_cnt = 0;
    bit m_pend = 1'b0, m_ien = 1'b0;

    always #2.5 clk = ~clk;

    serport_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_in_data(rx_in_data),
        .rx_in_valid(rx_in_valid), .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {24'd0, 3'd0, 1'(m_pend), 1'b0, 1'b1, 1'(m_cnt == 8), 1'(m_cnt != 0)};
    endfunction

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_in_data = b; rx_in_valid = 1'b1;
        @(negedge clk);
        rx_in_valid = 1'b0;
        if (m_cnt < 8) begin
            m_slot[m_wp] = b; m_wp = (m_wp + 1) % 8; m_cnt++;
        end
        if (m_cnt != 0) m_pend = 1'b1;
    endtask

    function automatic logic [7:0] model_pop();
        logic [7:0] v = m_slot[m_rp];
        if (m_cnt > 0) begin
            m_rp = (m_rp + 1) % 8; m_cnt--;
        end
        return v;
    endfunction

    task automatic read_rx(input string req, input logic [3:0] a);
        logic [31:0] d;
        logic [7:0] e;
        bus_read(a, d);
        e = model_pop();
        check(req, d, {24'd0, e});
        if (m_cnt != 0) m_pend = 1'b1;
    endtask

    task automatic read_status(input string req, input logic [3:0] a);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp_status());
        m_pend = (m_cnt != 0);
    endtask

    task automatic write_ctrl(input logic [31:0] v);
        bus_write(4'hC, v);
        m_ien = v[4];
        if (v[1]) begin m_wp = 0; m_rp = 0; m_cnt = 0; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 8; i++) m_slot[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 tx_valid", {31'd0, tx_out_valid}, 32'd0);
        bus_read(4'h8, d); check("R1 status", d, 32'h04);
        bus_read(4'hC, d); check("R1 control", d, 32'h0);
        bus_read(4'h0, d); check("R1 rxdata", d, 32'h0);

        // R3 R4 R5 R6: sweep fill levels 0..9, then drain. Unaligned addresses probe R2.
        for (int k = 0; k <= 9; k++) begin
            for (int i = 0; i < k; i++) push(8'(8'h30 + i * 7 + k * 13));
            read_status("R4 fill level", 4'(8 + (k % 4)));
            for (int i = 0; i < k && i < 8; i++) read_rx("R3 R5 order", 4'(k % 4));
            read_status("R4 drained", 4'h8);
            read_rx("R6 empty read", 4'h1);
            read_status("R6 still empty", 4'h8);
        end

        // R5 arrival while full, together with a read in the same cycle
        for (int i = 0; i < 8; i++) push(8'(8'hA0 + i));
        @(negedge clk);
        bus_addr = 4'h0; bus_rd = 1'b1; rx_in_data = 8'hEE; rx_in_valid = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; rx_in_valid = 1'b0;
        check("R5 read while full", d, {24'd0, model_pop()});
        read_status("R5 count after collision", 4'h8);
        for (int i = 0; i < 7; i++) read_rx("R5 contents unchanged", 4'h0);

        // R7 flush, with an arrival in the same cycle; flush bits read as zero
        push(8'h11); push(8'h22); push(8'h33);
        @(negedge clk);
        bus_addr = 4'hC; bus_wr = 1'b1; bus_wdata = 32'h13; rx_in_data = 8'h44; rx_in_valid = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_in_valid = 1'b0;
        m_wp = 0; m_rp = 0; m_cnt = 0; m_ien = 1'b1;
        read_status("R7 flushed", 4'h8);
        bus_read(4'hC, d); check("R7 control readback", d, 32'h10);
        read_rx("R7 empty read slot0", 4'h0);
        push(8'h55);
        read_rx("R7 refill", 4'h0);
        write_ctrl(32'h11);
        read_status("R7 bit0 no effect", 4'h8);

        // R8 transmit strobe, over several byte values
        for (int v = 0; v < 4; v++) begin
            bus_write(4'(4 + v), 32'hFFFF_FF00 | 32'(v * 8'h5B + 3));
            m_pend = 1'b1;
            check("R8 tx valid", {31'd0, tx_out_valid}, 32'd1);
            check("R8 tx data", {24'd0, tx_out_data}, 32'(8'(v * 8'h5B + 3)));
            @(negedge clk);
            check("R8 tx one cycle", {31'd0, tx_out_valid}, 32'd0);
        end

        // R9 R10 R11 over pend x enable
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 2; p++) begin
                write_ctrl(32'(e << 4));
                read_status("R10 clear", 4'h8);
                if (p == 1) begin bus_write(4'h4, 32'h5A); m_pend = 1'b1; end
                check("R9 R11 irq", {31'd0, irq}, {31'd0, 1'(m_pend && m_ien)});
                bus_read(4'hC, d); check("R11 enable readback", d, 32'(e << 4));
            end
        end

        // R10 status read does not clear while data waits
        push(8'h77);
        read_status("R10 nonempty", 4'h8);
        read_status("R10 sticky while nonempty", 4'h8);
        check("R11 irq with data", {31'd0, irq}, {31'd0, 1'(m_ien)});
        read_rx("R3 single", 4'h0);
        read_status("R10 last", 4'h8);
        read_status("R10 cleared", 4'h8);

        // R12 status writes ignored
        bus_write(4'h4, 32'h0); m_pend = 1'b1;
        bus_write(4'h8, 32'hFFFF_FFFF);
        bus_write(4'h9, 32'h0);
        read_status("R12 write ignored", 4'h8);
        bus_write(4'hA, 32'h0);
        read_status("R12 write ignored cleared", 4'h8);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule